// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the control state machine of a multicycle 32-bit load/store processor. On every rising clock edge it moves between the phases of one instruction: fetch, decode, then the phases that the 6-bit opcode calls for. In each phase it drives the datapath steering signals. These are the PC write enables, the memory address source, the memory read and write strobes, the instruction register load, the register file write controls, the ALU operand selects, the ALU operation class and the PC source. The outputs depend only on the current state.

The datapath must hold the opcode steady from the fetch that loaded it until the instruction's last phase. After that last phase the machine goes back to fetch on its own. An active-high clear forces the fetch state at once and holds it there while clear is high.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: While `clr` is high the machine is in the fetch state, entered asynchronously. The first state after `clr` falls is fetch, and a clear applied in the middle of an instruction abandons that instruction.
- R2: Fetch drives mem_rd=1, ir_wr=1, pc_wr=1, addr_data=0, alu_a_reg=0, alu_b_sel=001 (constant 4), alu_cls=00 (add) and pc_src=00 (ALU result). All other outputs are 0.
- R3: Decode, the second state of every instruction, drives alu_a_reg=0, alu_b_sel=011 (sign-extended immediate shifted left by 2) and alu_cls=00. All other outputs are 0. Decode picks the next state from the opcode.
- R4: Load (opcode 35) runs in five states. After decode come the address phase (alu_a_reg=1, alu_b_sel=010 sign-extended immediate, alu_cls=00), then the read phase (mem_rd=1, addr_data=1), then writeback (reg_wr=1, wb_mem=1, dst_rd=0).
- R5: Store (opcode 43) runs in four states. After decode come the same address phase as R4, then the write phase (mem_wr=1, addr_data=1).
- R6: Register-type operations (opcode 0) run in four states. After decode come execute (alu_a_reg=1, alu_b_sel=000 register B, alu_cls=10 funct decode), then writeback (reg_wr=1, wb_mem=0, dst_rd=1).
- R7: Immediate ALU operations run in four states. After decode come execute (alu_a_reg=1, alu_cls=11 opcode decode), then writeback (reg_wr=1, wb_mem=0, dst_rd=0). In execute, alu_b_sel is 010 (sign-extended) for add-immediate (8) and set-less-than-immediate (10), and 100 (zero-extended) for and-immediate (12) and or-immediate (13).
- R8: Branch-if-equal (opcode 4) runs in three states. The third drives alu_a_reg=1, alu_b_sel=000, alu_cls=01 (subtract), pc_wr_cond=1 and pc_src=01 (branch target), with pc_wr=0.
- R9: Jump (opcode 2) runs in three states. The third drives pc_wr=1 and pc_src=10 (jump target). All other outputs are 0.
- R10: Any other opcode goes from decode straight back to fetch.
- R11: The state after an instruction's last state is fetch.
- R12: mem_rd and mem_wr are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state changes on the rising edge |
| clr | input | 1 | Active-high clear to the fetch state |
| opcode | input | 6 | Opcode of the current instruction |
| pc_wr | output | 1 | Unconditional PC write |
| pc_wr_cond | output | 1 | PC write when the ALU result is zero |
| addr_data | output | 1 | Memory address from the ALU output register (1) or the PC (0) |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| ir_wr | output | 1 | Instruction register load |
| wb_mem | output | 1 | Register write data from memory (1) or the ALU (0) |
| reg_wr | output | 1 | Register file write |
| dst_rd | output | 1 | Destination register rd (1) or rt (0) |
| alu_a_reg | output | 1 | ALU input A from register A (1) or the PC (0) |
| alu_b_sel | output | 3 | ALU input B select |
| alu_cls | output | 2 | ALU operation class |
| pc_src | output | 2 | PC source select |

## Verification
The bench walks every opcode from clear to the fetch that follows it and compares the full control word in every state. A machine with a wrong transition would show up as a missing or extra phase, or as a stuck writeback with no return to fetch. The two pairs of immediate opcodes are tested apart, so a swapped zero-extend and sign-extend choice shows up as a wrong alu_b_sel in execute. An unused opcode is checked to return to fetch straight after decode. A clear raised in the middle of a load is checked to produce fetch outputs before the next clock edge and to keep them while clear is held, which a synchronous clear would not do.

// File: rtl/mc_ctrl_fsm.sv
module mc_ctrl_fsm #(
  parameter int OPW = 6
) (
  input  logic           clk,
  input  logic           clr,
  input  logic [OPW-1:0] opcode,
  output logic           pc_wr,
  output logic           pc_wr_cond,
  output logic           addr_data,
  output logic           mem_rd,
  output logic           mem_wr,
  output logic           ir_wr,
  output logic           wb_mem,
  output logic           reg_wr,
  output logic           dst_rd,
  output logic           alu_a_reg,
  output logic [2:0]     alu_b_sel,
  output logic [1:0]     alu_cls,
  output logic [1:0]     pc_src
);
  localparam logic [OPW-1:0] OP_RT   = OPW'(0);
  localparam logic [OPW-1:0] OP_J    = OPW'(2);
  localparam logic [OPW-1:0] OP_BEQ  = OPW'(4);
  localparam logic [OPW-1:0] OP_ADDI = OPW'(8);
  localparam logic [OPW-1:0] OP_SLTI = OPW'(10);
  localparam logic [OPW-1:0] OP_ANDI = OPW'(12);
  localparam logic [OPW-1:0] OP_ORI  = OPW'(13);
  localparam logic [OPW-1:0] OP_LW   = OPW'(35);
  localparam logic [OPW-1:0] OP_SW   = OPW'(43);

  typedef enum logic [3:0] {
    S_FETCH, S_DECODE, S_ADDR, S_MRD, S_MWB, S_MWR,
    S_EXR, S_WBR, S_BR, S_JMP, S_EXIS, S_EXIZ, S_WBI
  } state_t;

  state_t st, nx;

  always_ff @(posedge clk or posedge clr)
    if (clr) st <= S_FETCH;
    else     st <= nx;

  always_comb begin
    nx = S_FETCH;
    case (st)
      S_FETCH:  nx = S_DECODE;
      S_DECODE:
        case (opcode)
          OP_LW, OP_SW:       nx = S_ADDR;
          OP_RT:              nx = S_EXR;
          OP_BEQ:             nx = S_BR;
          OP_J:               nx = S_JMP;
          OP_ADDI, OP_SLTI:   nx = S_EXIS;
          OP_ANDI, OP_ORI:    nx = S_EXIZ;
          default:            nx = S_FETCH;
        endcase
      S_ADDR:   nx = (opcode == OP_LW) ? S_MRD : S_MWR;
      S_MRD:    nx = S_MWB;
      S_EXR:    nx = S_WBR;
      S_EXIS,
      S_EXIZ:   nx = S_WBI;
      default:  nx = S_FETCH;
    endcase
  end

  always_comb begin
    {pc_wr, pc_wr_cond, addr_data, mem_rd, mem_wr, ir_wr} = '0;
    {wb_mem, reg_wr, dst_rd, alu_a_reg} = '0;
    alu_b_sel = 3'b000;
    alu_cls   = 2'b00;
    pc_src    = 2'b00;
    case (st)
      S_FETCH: begin
        mem_rd = 1'b1; ir_wr = 1'b1; pc_wr = 1'b1; alu_b_sel = 3'b001;
      end
      S_DECODE: alu_b_sel = 3'b011;
      S_ADDR: begin
        alu_a_reg = 1'b1; alu_b_sel = 3'b010;
      end
      S_MRD: begin
        mem_rd = 1'b1; addr_data = 1'b1;
      end
      S_MWB: begin
        reg_wr = 1'b1; wb_mem = 1'b1;
      end
      S_MWR: begin
        mem_wr = 1'b1; addr_data = 1'b1;
      end
      S_EXR: begin
        alu_a_reg = 1'b1; alu_cls = 2'b10;
      end
      S_WBR: begin
        reg_wr = 1'b1; dst_rd = 1'b1;
      end
      S_BR: begin
        alu_a_reg = 1'b1; alu_cls = 2'b01; pc_wr_cond = 1'b1; pc_src = 2'b01;
      end
      S_JMP: begin
        pc_wr = 1'b1; pc_src = 2'b10;
      end
      S_EXIS: begin
        alu_a_reg = 1'b1; alu_b_sel = 3'b010; alu_cls = 2'b11;
      end
      S_EXIZ: begin
        alu_a_reg = 1'b1; alu_b_sel = 3'b100; alu_cls = 2'b11;
      end
      S_WBI: reg_wr = 1'b1;
      default: ;
    endcase
  end
endmodule

module mc_ctrl_fsm_chk (
  input logic       clk,
  input logic       clr,
  input logic       pc_wr,
  input logic       pc_wr_cond,
  input logic       mem_rd,
  input logic       mem_wr,
  input logic       ir_wr,
  input logic       wb_mem,
  input logic       reg_wr,
  input logic       dst_rd,
  input logic [2:0] alu_b_sel,
  input logic [1:0] alu_cls,
  input logic [1:0] pc_src
);
  assert_clr_fetch_R1: assert property (@(posedge clk)
    clr |-> (ir_wr && pc_wr && mem_rd && pc_src == 2'b00));

  assert_decode_next_R3: assert property (@(posedge clk) disable iff (clr)
    ir_wr |=> (!ir_wr && alu_b_sel == 3'b011 && alu_cls == 2'b00));

  assert_wb_mem_rt_R4: assert property (@(posedge clk) disable iff (clr)
    wb_mem |-> (reg_wr && !dst_rd));

  assert_branch_ctl_R8: assert property (@(posedge clk) disable iff (clr)
    pc_wr_cond |-> (alu_cls == 2'b01 && pc_src == 2'b01 && !pc_wr));

  assert_back_to_fetch_R11: assert property (@(posedge clk) disable iff (clr)
    (reg_wr || mem_wr || pc_wr_cond || (pc_wr && pc_src == 2'b10)) |=> ir_wr);

  assert_mem_excl_R12: assert property (@(posedge clk) disable iff (clr)
    !(mem_rd && mem_wr));
endmodule

bind mc_ctrl_fsm mc_ctrl_fsm_chk u_chk (
  .clk(clk), .clr(clr), .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond),
  .mem_rd(mem_rd), .mem_wr(mem_wr), .ir_wr(ir_wr), .wb_mem(wb_mem),
  .reg_wr(reg_wr), .dst_rd(dst_rd), .alu_b_sel(alu_b_sel),
  .alu_cls(alu_cls), .pc_src(pc_src)
);

// File: tb/sim_mc_ctrl_fsm.sv
`timescale 1ns/1ps
module sim_mc_ctrl_fsm;
  logic       clk = 1'b0;
  logic       clr = 1'b1;
  logic [5:0] opcode = 6'd0;
  logic pc_wr, pc_wr_cond, addr_data, mem_rd, mem_wr, ir_wr;
  logic wb_mem, reg_wr, dst_rd, alu_a_reg;
  logic [2:0] alu_b_sel;
  logic [1:0] alu_cls, pc_src;

  int tests = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  mc_ctrl_fsm u0 (
    .clk(clk), .clr(clr), .opcode(opcode), .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond),
    .addr_data(addr_data), .mem_rd(mem_rd), .mem_wr(mem_wr), .ir_wr(ir_wr),
    .wb_mem(wb_mem), .reg_wr(reg_wr), .dst_rd(dst_rd), .alu_a_reg(alu_a_reg),
    .alu_b_sel(alu_b_sel), .alu_cls(alu_cls), .pc_src(pc_src)
  );

  // word: pc_wr pc_wr_cond addr_data mem_rd mem_wr ir_wr wb_mem reg_wr dst_rd alu_a_reg | b[3] cls[2] src[2]
  localparam logic [16:0] K_FETCH  = {10'b1001010000, 3'b001, 2'b00, 2'b00};
  localparam logic [16:0] K_DECODE = {10'b0000000000, 3'b011, 2'b00, 2'b00};
  localparam logic [16:0] K_ADDR   = {10'b0000000001, 3'b010, 2'b00, 2'b00};
  localparam logic [16:0] K_MRD    = {10'b0011000000, 3'b000, 2'b00, 2'b00};
  localparam logic [16:0] K_MWB    = {10'b0000001100, 3'b000, 2'b00, 2'b00};
  localparam logic [16:0] K_MWR    = {10'b0010100000, 3'b000, 2'b00, 2'b00};
  localparam logic [16:0] K_EXR    = {10'b0000000001, 3'b000, 2'b10, 2'b00};
  localparam logic [16:0] K_WBR    = {10'b0000000110, 3'b000, 2'b00, 2'b00};
  localparam logic [16:0] K_BR     = {10'b0100000001, 3'b000, 2'b01, 2'b01};
  localparam logic [16:0] K_JMP    = {10'b1000000000, 3'b000, 2'b00, 2'b10};
  localparam logic [16:0] K_EXIS   = {10'b0000000001, 3'b010, 2'b11, 2'b00};
  localparam logic [16:0] K_EXIZ   = {10'b0000000001, 3'b100, 2'b11, 2'b00};
  localparam logic [16:0] K_WBI    = {10'b0000000100, 3'b000, 2'b00, 2'b00};

  function automatic logic [16:0] word();
    return {pc_wr, pc_wr_cond, addr_data, mem_rd, mem_wr, ir_wr, wb_mem, reg_wr,
            dst_rd, alu_a_reg, alu_b_sel, alu_cls, pc_src};
  endfunction

  task automatic chk(string req, logic [16:0] exp);
    tests++;
    if (word() !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b at %0t", req, word(), exp, $time);
    end
  endtask

  task automatic next_cycle();
    @(negedge clk); #5;
  endtask

  task automatic start(logic [5:0] op);
    @(negedge clk); clr = 1'b1; opcode = op;
    @(negedge clk); clr = 1'b0; #5;
  endtask

  task automatic run_op(string req, logic [5:0] op, int n,
                        logic [16:0] s2, logic [16:0] s3, logic [16:0] s4);
    logic [16:0] seq [5];
    seq[0] = K_FETCH; seq[1] = K_DECODE; seq[2] = s2; seq[3] = s3; seq[4] = s4;
    start(op);
    chk("R1 first state fetch", K_FETCH);
    for (int i = 1; i < n; i++) begin
      next_cycle();
      chk(i == 1 ? "R3 decode" : req, seq[i]);
    end
    next_cycle();
    chk("R11 back to fetch", K_FETCH);
    next_cycle();
    chk("R11 next decode", K_DECODE);
  endtask

  task automatic t_reset();
    #5;
    chk("R1 held in clear", K_FETCH);
    next_cycle();
    chk("R1 held in clear after edge", K_FETCH);
    chk("R2 fetch word", K_FETCH);
  endtask

  task automatic t_unknown(logic [5:0] op);
    start(op);
    chk("R1 first state fetch", K_FETCH);
    next_cycle();
    chk("R3 decode", K_DECODE);
    next_cycle();
    chk("R10 unknown opcode to fetch", K_FETCH);
  endtask

  task automatic t_mid_clear();
    start(6'd35);
    next_cycle();
    next_cycle();
    chk("R4 address phase", K_ADDR);
    @(negedge clk); clr = 1'b1; #2;
    chk("R1 async clear mid instruction", K_FETCH);
    next_cycle();
    chk("R1 clear held across edge", K_FETCH);
    @(negedge clk); clr = 1'b0; #5;
    chk("R1 fetch after release", K_FETCH);
    next_cycle();
    chk("R3 decode after clear", K_DECODE);
  endtask

  initial begin
    t_reset();
    run_op("R4 load",         6'd35, 5, K_ADDR, K_MRD, K_MWB);
    run_op("R5 store",        6'd43, 4, K_ADDR, K_MWR, K_FETCH);
    run_op("R6 register op",  6'd0,  4, K_EXR,  K_WBR, K_FETCH);
    run_op("R8 branch",       6'd4,  3, K_BR,   K_FETCH, K_FETCH);
    run_op("R9 jump",         6'd2,  3, K_JMP,  K_FETCH, K_FETCH);
    run_op("R7 addi",         6'd8,  4, K_EXIS, K_WBI, K_FETCH);
    run_op("R7 slti",         6'd10, 4, K_EXIS, K_WBI, K_FETCH);
    run_op("R7 andi",         6'd12, 4, K_EXIZ, K_WBI, K_FETCH);
    run_op("R7 ori",          6'd13, 4, K_EXIZ, K_WBI, K_FETCH);
    t_unknown(6'd1);
    t_unknown(6'd63);
    t_mid_clear();
    tests++;
    if (mem_rd && mem_wr) begin
      fails++;
      $display("FAIL R12: mem_rd=%b mem_wr=%b expected not both", mem_rd, mem_wr);
    end
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog: run incomplete, expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule